// File: doc/BRIEF.md
# Windowed-Sum Spike Classifier

This block sorts detected neural spikes into one of two neuron classes. Digitised electrode samples arrive one per cycle when a valid strobe is high, and a separate detection strobe marks the sample at which a spike begins. From that sample onward the block adds up the samples that fall inside two programmable offset windows. Each of the two sums is compared with its own threshold, and the pair of comparisons selects the class.

Adding up samples before any comparison averages out noise. A single sample taken at one chosen instant would be more exposed to it. Window bounds and thresholds are worked out offline from training data and written into a small register file. For every accepted spike the block reports a time stamp and a one-bit neuron ID.

The controller is a three-state machine:
- **IDLE** waits for a detection.
- **COLLECT** accumulates window samples.
- **DECIDE** presents the result for one cycle.

Its transitions are:
- IDLE→COLLECT on an accepted detection when the later window end is nonzero.
- IDLE→DECIDE on an accepted detection when both window ends are zero.
- COLLECT→DECIDE when the sample at the later window end is accepted.
- DECIDE→IDLE unconditionally.

Top module: `wsc_classifier`

## Requirements
- R1: After reset, `res_vld` and `res_class` are low and the sample time counter is zero, so the first accepted sample carries stamp 0.
- R2: `res_stamp` equals the number of samples accepted (`smp_vld` high) since reset before the detection sample, modulo 2^16.
- R3: Offsets count accepted samples only. The detection sample is offset 0, and cycles with `smp_vld` low do not advance the offset. Window k sums every sample whose offset lies in its inclusive range from start_k to end_k (0 to 63). Samples are signed 8-bit values.
- R4: A window whose start is greater than its end contributes a sum of zero.
- R5: `res_class` is 1 exactly when sum0 > thr0 and sum1 > thr1, using signed 14-bit compares. Otherwise it is 0. The 14-bit sums hold 64 samples of -128 or +127 without overflow.
- R6: `res_vld` is high for exactly one cycle: the cycle that follows the clock edge accepting the sample at offset max(end0, end1).
- R7: A detection strobe is ignored in three cases: when `smp_vld` is low, while a spike is being collected, and during the result cycle. An ignored strobe produces no result and does not change the stamp.
- R8: Window bounds and thresholds are captured when a detection is accepted. Register writes made while a spike is in progress affect only later spikes.
- R9: Register write map, taking `cfg_wdata` low bits:
  - Address 0 writes start0 and address 1 writes end0.
  - Address 2 writes start1 and address 3 writes end1.
  - Address 4 writes thr0 and address 5 writes thr1.
  - Offsets use bits 5:0; thresholds use bits 13:0 as a signed value.
  - Writes to addresses 6 and 7 change nothing.
  - All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample present this cycle |
| smp_data | input | 8 | Signed sample value |
| det_strobe | input | 1 | Spike detected at the current sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 14 | Register write data |
| res_vld | output | 1 | Classification result valid |
| res_stamp | output | 16 | Time stamp of the detection sample |
| res_class | output | 1 | Neuron ID (0 or 1) |

## Verification
Some properties are checked by assertions on every cycle:
- The result pulse lasts one cycle and follows an accepted sample.
- The machine returns to idle after a result.
- The sample counter advances by one on each accepted sample.
- The stamp stays fixed while a spike is in progress.

The bench scenarios alone can show the rest:
- The actual window sums and the class decision, including the sign limits at 64 samples and inverted windows.
- The exact result cycle when valid gaps stretch a spike.
- Detections that are dropped.
- Register writes during a spike, and writes to unused addresses.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    localparam int unsigned N_WIN  = 2;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2
    } wsc_state_e;

    // Register addresses; window g uses 2*g and 2*g+1, threshold g uses 4+g.
    localparam logic [ADDR_W-1:0] RA_THR_BASE = 3'd4;

endpackage

// File: rtl/wsc_cfg_regs.sv
module wsc_cfg_regs
    import wsc_pkg::*;
#(
    parameter int unsigned OFS_W = 6,
    parameter int unsigned ACC_W = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [ACC_W-1:0]             cfg_wdata,
    output logic [N_WIN-1:0][OFS_W-1:0]  win_start,
    output logic [N_WIN-1:0][OFS_W-1:0]  win_end,
    output logic [N_WIN-1:0][ACC_W-1:0]  win_thr
);

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        localparam logic [ADDR_W-1:0] A_START = ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(2 * g + 1);
        localparam logic [ADDR_W-1:0] A_THR   = RA_THR_BASE + ADDR_W'(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_start[g] <= '0;
                win_end[g]   <= '0;
                win_thr[g]   <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == A_START) win_start[g] <= cfg_wdata[OFS_W-1:0];
                if (cfg_addr == A_END)   win_end[g]   <= cfg_wdata[OFS_W-1:0];
                if (cfg_addr == A_THR)   win_thr[g]   <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/wsc_sample_clock.sv
module wsc_sample_clock #(
    parameter int unsigned TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_vld,
    output logic [TS_W-1:0] ts_now
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_now <= '0;
        end else if (smp_vld) begin
            ts_now <= ts_now + TS_W'(1);
        end
    end

endmodule

// File: rtl/wsc_window_acc.sv
module wsc_window_acc #(
    parameter int unsigned OFS_W = 6,
    parameter int unsigned SMP_W = 8,
    parameter int unsigned ACC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,      // first sample of a spike: restart sum
    input  logic             step,      // later sample of the same spike
    input  logic [OFS_W-1:0] offset,
    input  logic [OFS_W-1:0] lo,
    input  logic [OFS_W-1:0] hi,
    input  logic [SMP_W-1:0] sample,
    output logic [ACC_W-1:0] sum
);

    localparam int unsigned EXT_W = ACC_W - SMP_W;

    logic             in_win;
    logic [ACC_W-1:0] addend;

    always_comb begin
        in_win = (offset >= lo) && (offset <= hi);
        addend = in_win ? {{EXT_W{sample[SMP_W-1]}}, sample} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (load) begin
            sum <= addend;
        end else if (step) begin
            sum <= sum + addend;
        end
    end

endmodule

// File: rtl/wsc_classifier.sv
module wsc_classifier
    import wsc_pkg::*;
#(
    parameter int unsigned SMP_W = 8,
    parameter int unsigned OFS_W = 6,
    parameter int unsigned ACC_W = 14,
    parameter int unsigned TS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              det_strobe,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ACC_W-1:0]  cfg_wdata,
    output logic              res_vld,
    output logic [TS_W-1:0]   res_stamp,
    output logic              res_class
);

    wsc_state_e state_q, state_d;

    logic [N_WIN-1:0][OFS_W-1:0] live_start, live_end;
    logic [N_WIN-1:0][ACC_W-1:0] live_thr;
    logic [N_WIN-1:0][OFS_W-1:0] snap_start, snap_end;
    logic [N_WIN-1:0][ACC_W-1:0] snap_thr;
    logic [N_WIN-1:0][OFS_W-1:0] eff_start, eff_end;
    logic [N_WIN-1:0][ACC_W-1:0] sums;
    logic [N_WIN-1:0]            above;

    logic [OFS_W-1:0] live_max, snap_max;
    logic [OFS_W-1:0] ofs_q, cur_ofs;
    logic [TS_W-1:0]  ts_now, stamp_q;
    logic             accept, step, last, busy;

    wsc_cfg_regs #(.OFS_W(OFS_W), .ACC_W(ACC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .win_start (live_start),
        .win_end   (live_end),
        .win_thr   (live_thr)
    );

    wsc_sample_clock #(.TS_W(TS_W)) u_clock (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .ts_now  (ts_now)
    );

    // Control strobes
    always_comb begin
        accept   = (state_q == ST_IDLE) && smp_vld && det_strobe;
        step     = (state_q == ST_COLLECT) && smp_vld;
        last     = step && (ofs_q == snap_max);
        busy     = (state_q != ST_IDLE);
        cur_ofs  = (state_q == ST_IDLE) ? '0 : ofs_q;
        live_max = (live_end[0] > live_end[1]) ? live_end[0] : live_end[1];
    end

    // Parameter snapshot taken at the accepted detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_start <= '0;
            snap_end   <= '0;
            snap_thr   <= '0;
            snap_max   <= '0;
            stamp_q    <= '0;
        end else if (accept) begin
            snap_start <= live_start;
            snap_end   <= live_end;
            snap_thr   <= live_thr;
            snap_max   <= live_max;
            stamp_q    <= ts_now;
        end
    end

    // Offset of the next sample within the spike
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (accept) begin
            ofs_q <= OFS_W'(1);
        end else if (step) begin
            ofs_q <= ofs_q + OFS_W'(1);
        end
    end

    // Window accumulators and threshold compares
    for (genvar g = 0; g < N_WIN; g++) begin : g_acc
        always_comb begin
            eff_start[g] = accept ? live_start[g] : snap_start[g];
            eff_end[g]   = accept ? live_end[g]   : snap_end[g];
            above[g]     = $signed(sums[g]) > $signed(snap_thr[g]);
        end

        wsc_window_acc #(.OFS_W(OFS_W), .SMP_W(SMP_W), .ACC_W(ACC_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (accept),
            .step   (step),
            .offset (cur_ofs),
            .lo     (eff_start[g]),
            .hi     (eff_end[g]),
            .sample (smp_data),
            .sum    (sums[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (live_max == '0) ? ST_DECIDE : ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (last) begin
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        res_vld   = (state_q == ST_DECIDE);
        res_stamp = stamp_q;
        res_class = res_vld && (&above);
    end

endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
    parameter int unsigned TS_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            smp_vld,
    input logic            res_vld,
    input logic            res_class,
    input logic            busy,
    input logic [TS_W-1:0] ts_now,
    input logic [TS_W-1:0] res_stamp
);

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld); // R6

    AST_VLD_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_vld) |-> $past(smp_vld)); // R6

    AST_IDLE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !busy); // R6

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> (ts_now == $past(ts_now) + TS_W'(1))); // R2

    AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(ts_now)); // R2

    AST_STAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(res_stamp)); // R7

    AST_CLASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> !res_class); // R5

endmodule

bind wsc_classifier wsc_checker #(.TS_W(TS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .res_vld   (res_vld),
    .res_class (res_class),
    .busy      (busy),
    .ts_now    (ts_now),
    .res_stamp (res_stamp)
);

// File: tb/sim_wsc_classifier.sv
module sim_wsc_classifier;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_vld;
    logic [7:0]  smp_data;
    logic        det_strobe;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [13:0] cfg_wdata;
    logic        res_vld;
    logic [15:0] res_stamp;
    logic        res_class;

    wsc_classifier u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .smp_data   (smp_data),
        .det_strobe (det_strobe),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .res_vld    (res_vld),
        .res_stamp  (res_stamp),
        .res_class  (res_class)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int stamp;
        int cls;
        int cyc;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc    = 0;
    int          ts_cnt = 0;
    int          results = 0;
    int          pushed  = 0;
    logic [31:0] lcg = 32'h1234_5678;
    int          m_start[2], m_end[2], m_thr[2];
    bit          finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int next_sample();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'($signed(lcg[23:16]));
    endfunction

    // Bench model of the register map (R9)
    function automatic void model_write(input logic [2:0] a, input logic [13:0] d);
        case (a)
            3'd0: m_start[0] = int'(d[5:0]);
            3'd1: m_end[0]   = int'(d[5:0]);
            3'd2: m_start[1] = int'(d[5:0]);
            3'd3: m_end[1]   = int'(d[5:0]);
            3'd4: m_thr[0]   = int'($signed(d));
            3'd5: m_thr[1]   = int'($signed(d));
            default: ;
        endcase
    endfunction

    task automatic cfg_write(input logic [2:0] a, input logic [13:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        model_write(a, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: one spike, expected result pushed to the scoreboard
    task automatic send_spike(input int tail, input int gap_every, input int extra_det,
                              input int wr_at, input logic [2:0] wa, input logic [13:0] wd,
                              input int cval);
        int s[2];
        int ls[2], le[2], lt[2];
        int maxe, stamp, v;
        exp_t it;
        for (int g = 0; g < 2; g++) begin
            s[g] = 0; ls[g] = m_start[g]; le[g] = m_end[g]; lt[g] = m_thr[g];
        end
        maxe  = (le[0] > le[1]) ? le[0] : le[1];
        stamp = 0;
        for (int o = 0; o <= maxe + tail; o++) begin
            if (gap_every > 0 && o > 0 && (o % gap_every) == 0) begin
                smp_vld = 1'b0; det_strobe = 1'b1; cfg_we = 1'b0;
                @(negedge clk);
            end
            v = (cval >= -128 && cval <= 127) ? cval : next_sample();
            smp_vld = 1'b1; smp_data = v[7:0];
            det_strobe = (o == 0) || (o == extra_det);
            if (o == wr_at) begin
                cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
                model_write(wa, wd);
            end else begin
                cfg_we = 1'b0;
            end
            if (o == 0) stamp = ts_cnt;
            for (int g = 0; g < 2; g++)
                if (o >= ls[g] && o <= le[g]) s[g] += v;
            if (o == maxe) begin
                it.stamp = stamp % 65536;
                it.cls   = ((s[0] > lt[0]) && (s[1] > lt[1])) ? 1 : 0;
                it.cyc   = cyc + 1;
                exp_q.push_back(it);
                pushed++;
            end
            ts_cnt++;
            @(negedge clk);
        end
        smp_vld = 1'b0; det_strobe = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compares each result against the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1 && res_vld === 1'b1) begin
            exp_t e;
            results++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected result", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(int'(res_stamp) == e.stamp, "R2 stamp", int'(res_stamp), e.stamp);
                check(int'(res_class) == e.cls, "R5 class (R3/R4 sums)", int'(res_class), e.cls);
                check(cyc == e.cyc, "R6 result cycle", cyc, e.cyc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 2; g++) begin
            m_start[g] = 0; m_end[g] = 0; m_thr[g] = 0;
        end
        rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0; det_strobe = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_vld == 1'b0, "R1 res_vld after reset", int'(res_vld), 0);
        check(res_class == 1'b0, "R1 res_class after reset", int'(res_class), 0);

        // R1/R3: default windows are offset 0 only, thresholds 0
        for (int k = 0; k < 4; k++) send_spike(2, 0, -1, -1, 3'd0, 14'd0, 1000);

        // R7: detection without a valid sample is ignored
        det_strobe = 1'b1; smp_vld = 1'b0;
        @(negedge clk);
        det_strobe = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && results == pushed, "R7 det without sample", results, pushed);

        // R3: two overlapping windows, with and without valid gaps
        cfg_write(3'd0, 14'd2);  cfg_write(3'd1, 14'd9);
        cfg_write(3'd2, 14'd5);  cfg_write(3'd3, 14'd20);
        for (int k = 0; k < 4; k++) send_spike(1, 0, -1, -1, 3'd0, 14'd0, 1000);
        for (int k = 0; k < 3; k++) send_spike(1, 4, -1, -1, 3'd0, 14'd0, 1000);

        // R7: detections while collecting and during the result cycle
        send_spike(2, 0, 3, -1, 3'd0, 14'd0, 1000);
        send_spike(2, 0, 21, -1, 3'd0, 14'd0, 1000);

        // R4: inverted window sums to zero
        cfg_write(3'd2, 14'd12); cfg_write(3'd3, 14'd4);
        cfg_write(3'd5, 14'h3FFF);               // thr1 = -1
        for (int k = 0; k < 3; k++) send_spike(1, 0, -1, -1, 3'd0, 14'd0, 1000);
        cfg_write(3'd5, 14'd0);                  // thr1 = 0: sum1 = 0 never exceeds
        for (int k = 0; k < 2; k++) send_spike(1, 0, -1, -1, 3'd0, 14'd0, 40);

        // R8: write during a spike applies only to the next one
        cfg_write(3'd5, 14'h3FFF);
        send_spike(1, 0, -1, 2, 3'd4, 14'h1FFF, 30);   // thr0 -> 8191 mid-spike
        send_spike(1, 0, -1, -1, 3'd0, 14'd0, 30);
        cfg_write(3'd4, 14'd0);

        // R9: unused addresses change nothing
        cfg_write(3'd6, 14'h1FFF);
        cfg_write(3'd7, 14'h1FFF);
        for (int k = 0; k < 2; k++) send_spike(1, 0, -1, -1, 3'd0, 14'd0, 50);

        // R5: full-width windows at the numeric limits
        cfg_write(3'd0, 14'd0); cfg_write(3'd1, 14'd63);
        cfg_write(3'd2, 14'd0); cfg_write(3'd3, 14'd63);
        cfg_write(3'd4, 14'd8127); cfg_write(3'd5, 14'd8127);
        send_spike(1, 0, -1, -1, 3'd0, 14'd0, 127);     // 8128 > 8127
        cfg_write(3'd5, 14'd8128);
        send_spike(1, 0, -1, -1, 3'd0, 14'd0, 127);     // 8128 > 8128 false
        cfg_write(3'd4, 14'h2000); cfg_write(3'd5, 14'h2000); // -8192
        send_spike(1, 0, -1, -1, 3'd0, 14'd0, -128);    // -8192 > -8192 false
        cfg_write(3'd4, 14'h2001); cfg_write(3'd5, 14'h2001); // -8191
        send_spike(1, 0, -1, -1, 3'd0, 14'd0, -127);    // -8128 > -8191 true

        // R3/R6: single-point windows far apart, latest end 63
        cfg_write(3'd0, 14'd1);  cfg_write(3'd1, 14'd1);
        cfg_write(3'd2, 14'd63); cfg_write(3'd3, 14'd63);
        cfg_write(3'd4, 14'd0);  cfg_write(3'd5, 14'd0);
        for (int k = 0; k < 4; k++) send_spike(1, 9, -1, -1, 3'd0, 14'd0, 1000);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R6 missing results", exp_q.size(), 0);
        check(results == pushed, "R7 result count", results, pushed);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule